// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

This block follows a linked list of transmit descriptors held in a shared word-addressed memory. The host gives it a start pointer. For each descriptor it reads a forward pointer and a control word through a simple request/response memory port. At every frame boundary it writes a completion code into the status word of the descriptor that opened the frame. It reports what it sees as one-cycle event pulses, each paired with the address of the descriptor the event refers to.

A forward pointer with its least significant bit set marks the end of the chain. After the end-of-chain frame is reported, the walker reads that pointer again before it declares the command finished. A host can therefore append a descriptor late by overwriting the pointer with an even address, and the walk then continues. Moving the payload and delivering interrupts are left to other blocks.

Each descriptor occupies three consecutive words: the forward pointer at offset 0, the control word at offset `CTL_OFS` (default 1), and the status word at offset `STAT_OFS` (default 2).

Top module: `txd_chain_walker`

## Requirements
- R1: After reset, `busy`, `mem_valid`, `evt_frame`, `evt_cmd` and `evt_lerr` are all low.
- R2: When `start` is high while the walker is idle, it loads `start_ptr` and reads the word at that address, then the word at address+`CTL_OFS`. `busy` is high from the cycle after `start` until the cycle after `evt_cmd` or `evt_lerr` is posted.
- R3: Control word layout: bit 0 is start-of-frame, bit 1 is end-of-frame, bit 2 requests a frame-complete event, and bits [FRAG_LSB +: FRAG_W] hold the fragment count. A start-of-frame bit makes that descriptor the frame's owner.
- R4: A frame ends at a descriptor whose end-of-frame bit is set or whose forward pointer is odd. At that point `DONE_CODE` is written to owner address+`STAT_OFS`, and no other status word is written.
- R5: After that status write is accepted, `evt_frame` pulses, carrying the owner address on `evt_addr`. This happens only if the frame-ending descriptor has its request bit set.
- R6: When the frame-ending descriptor has an odd forward pointer, that pointer is reread from memory after the frame-complete step. If it is still odd, `evt_cmd` pulses with that descriptor's address, and then the walker goes idle.
- R7: If the reread pointer is now even, the walk continues at the new address without posting `evt_cmd`.
- R8: `evt_frame`, `evt_cmd` and `evt_lerr` are never high in the same cycle.
- R9: A descriptor with a zero fragment count raises `evt_lerr` with its own address. No status is written for it, and the walk stops until the next `start`.
- R10: A memory request holds `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_ready`. A read waits for `mem_rvalid` however long the stall lasts.
- R11: `start` while `busy` is high has no effect on the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk at `start_ptr` when idle |
| start_ptr | input | AW | Address of the first descriptor |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request word address |
| mem_wdata | output | DW | Write data (completion code) |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| busy | output | 1 | Walk in progress |
| evt_frame | output | 1 | Frame-complete event pulse |
| evt_cmd | output | 1 | Command-complete event pulse |
| evt_lerr | output | 1 | List-error event pulse |
| evt_addr | output | AW | Descriptor address of the current event |

## Verification
The bench builds the walker with an 8-bit address and 16-bit data, so a 256-word memory model holds every chain the bench uses and each write stays visible for inspection. The fragment field sits at bits 4 to 11, which lets the bench build zero-count descriptors by hand. A stall mode drops `mem_ready` one cycle in four. This holds requests across several edges and exercises the wait states. The memory model also gives the bench a direct way to rewrite a forward pointer while the walker sits between the frame-complete pulse and its reread.

// File: rtl/txw_pkg.sv
package txw_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_FWD_REQ, S_FWD_WAIT, S_CTL_REQ, S_CTL_WAIT, S_DECIDE,
    S_STAT_WR, S_FC_POST, S_RE_REQ, S_RE_WAIT, S_CC_POST, S_LE_POST
  } walk_state_e;

  localparam int unsigned BIT_SOF = 0;
  localparam int unsigned BIT_EOF = 1;
  localparam int unsigned BIT_FCQ = 2;
endpackage

// File: rtl/txw_ctl_decode.sv
module txw_ctl_decode #(
  parameter int unsigned DW       = 16,
  parameter int unsigned FRAG_LSB = 4,
  parameter int unsigned FRAG_W   = 8
) (
  input  logic [DW-1:0] ctl,
  output logic          is_sof,
  output logic          is_eof,
  output logic          want_fc,
  output logic          frag_zero
);
  import txw_pkg::*;
  localparam int unsigned FRAG_TOP = FRAG_LSB + FRAG_W;

  logic unused_bits;

  assign is_sof    = ctl[BIT_SOF];
  assign is_eof    = ctl[BIT_EOF];
  assign want_fc   = ctl[BIT_FCQ];
  assign frag_zero = (ctl[FRAG_LSB +: FRAG_W] == '0);

  generate
    if (FRAG_TOP < DW) begin : g_hi
      assign unused_bits = ^{ctl[DW-1:FRAG_TOP], ctl[FRAG_LSB-1:BIT_FCQ+1]};
    end else begin : g_nohi
      assign unused_bits = ^ctl[FRAG_LSB-1:BIT_FCQ+1];
    end
  endgenerate
endmodule

// File: rtl/txw_walk_fsm.sv
module txw_walk_fsm #(
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 16,
  parameter int unsigned CTL_OFS   = 1,
  parameter int unsigned STAT_OFS  = 2,
  parameter logic [DW-1:0] DONE_CODE = 16'h8001
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [AW-1:0]        start_ptr,
  input  logic                 mem_ready,
  input  logic                 mem_rvalid,
  input  logic [DW-1:0]        mem_rdata,
  input  logic                 is_sof,
  input  logic                 is_eof,
  input  logic                 want_fc,
  input  logic                 frag_zero,
  output txw_pkg::walk_state_e state_q,
  output logic [AW-1:0]        cur_q,
  output logic [AW-1:0]        own_q,
  output logic [AW-1:0]        fwd_q,
  output logic [DW-1:0]        ctl_q,
  output logic                 mem_valid,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_wdata
);
  import txw_pkg::*;
  localparam logic [AW-1:0] CTL_INC  = AW'(CTL_OFS);
  localparam logic [AW-1:0] STAT_INC = AW'(STAT_OFS);

  walk_state_e   state_d;
  logic [AW-1:0] cur_d, own_d, fwd_d;
  logic [DW-1:0] ctl_d;

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    own_d   = own_q;
    fwd_d   = fwd_q;
    ctl_d   = ctl_q;
    unique case (state_q)
      S_IDLE: if (start) begin
        cur_d   = start_ptr;
        own_d   = start_ptr;
        state_d = S_FWD_REQ;
      end
      S_FWD_REQ:  if (mem_ready) state_d = S_FWD_WAIT;
      S_FWD_WAIT: if (mem_rvalid) begin
        fwd_d   = mem_rdata[AW-1:0];
        state_d = S_CTL_REQ;
      end
      S_CTL_REQ:  if (mem_ready) state_d = S_CTL_WAIT;
      S_CTL_WAIT: if (mem_rvalid) begin
        ctl_d   = mem_rdata;
        state_d = S_DECIDE;
      end
      S_DECIDE: begin
        if (frag_zero) begin
          state_d = S_LE_POST;
        end else begin
          if (is_sof) own_d = cur_q;
          if (is_eof || fwd_q[0]) begin
            state_d = S_STAT_WR;
          end else begin
            cur_d   = fwd_q;
            state_d = S_FWD_REQ;
          end
        end
      end
      S_STAT_WR: if (mem_ready) begin
        if (want_fc) begin
          state_d = S_FC_POST;
        end else if (fwd_q[0]) begin
          state_d = S_RE_REQ;
        end else begin
          cur_d   = fwd_q;
          own_d   = fwd_q;
          state_d = S_FWD_REQ;
        end
      end
      S_FC_POST: begin
        if (fwd_q[0]) begin
          state_d = S_RE_REQ;
        end else begin
          cur_d   = fwd_q;
          own_d   = fwd_q;
          state_d = S_FWD_REQ;
        end
      end
      S_RE_REQ:  if (mem_ready) state_d = S_RE_WAIT;
      S_RE_WAIT: if (mem_rvalid) begin
        fwd_d = mem_rdata[AW-1:0];
        if (mem_rdata[0]) begin
          state_d = S_CC_POST;
        end else begin
          cur_d   = mem_rdata[AW-1:0];
          own_d   = mem_rdata[AW-1:0];
          state_d = S_FWD_REQ;
        end
      end
      S_CC_POST: state_d = S_IDLE;
      S_LE_POST: state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cur_q   <= '0;
      own_q   <= '0;
      fwd_q   <= '0;
      ctl_q   <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      own_q   <= own_d;
      fwd_q   <= fwd_d;
      ctl_q   <= ctl_d;
    end
  end

  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_q;
    unique case (state_q)
      S_FWD_REQ, S_RE_REQ: mem_valid = 1'b1;
      S_CTL_REQ: begin
        mem_valid = 1'b1;
        mem_addr  = cur_q + CTL_INC;
      end
      S_STAT_WR: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = own_q + STAT_INC;
      end
      default: ;
    endcase
  end
  assign mem_wdata = DONE_CODE;

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

  // R5
  fc_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FC_POST) |-> $past(mem_valid && mem_we && mem_ready));
endmodule

// File: rtl/txw_evt_out.sv
module txw_evt_out #(
  parameter int unsigned AW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  txw_pkg::walk_state_e state_q,
  input  logic [AW-1:0]        cur_q,
  input  logic [AW-1:0]        own_q,
  input  logic                 fwd_odd,
  output logic                 busy,
  output logic                 evt_frame,
  output logic                 evt_cmd,
  output logic                 evt_lerr,
  output logic [AW-1:0]        evt_addr
);
  import txw_pkg::*;

  assign busy      = (state_q != S_IDLE);
  assign evt_frame = (state_q == S_FC_POST);
  assign evt_cmd   = (state_q == S_CC_POST);
  assign evt_lerr  = (state_q == S_LE_POST);
  assign evt_addr  = evt_frame ? own_q : cur_q;

  // R8
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_frame, evt_cmd, evt_lerr}));

  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(evt_cmd || evt_lerr));

  // R9
  lerr_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_lerr |=> !busy);

  // R6
  cmd_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cmd |-> (fwd_odd && $past(busy)));
endmodule

// File: rtl/txd_chain_walker.sv
module txd_chain_walker #(
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 16,
  parameter int unsigned FRAG_LSB  = 4,
  parameter int unsigned FRAG_W    = 8,
  parameter int unsigned CTL_OFS   = 1,
  parameter int unsigned STAT_OFS  = 2,
  parameter logic [DW-1:0] DONE_CODE = 16'h8001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_ptr,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          evt_frame,
  output logic          evt_cmd,
  output logic          evt_lerr,
  output logic [AW-1:0] evt_addr
);
  import txw_pkg::*;

  walk_state_e   state_q;
  logic [AW-1:0] cur_q, own_q, fwd_q;
  logic [DW-1:0] ctl_q;
  logic          is_sof, is_eof, want_fc, frag_zero;

  txw_ctl_decode #(.DW(DW), .FRAG_LSB(FRAG_LSB), .FRAG_W(FRAG_W)) u_dec (
    .ctl(ctl_q), .is_sof(is_sof), .is_eof(is_eof),
    .want_fc(want_fc), .frag_zero(frag_zero)
  );

  txw_walk_fsm #(.AW(AW), .DW(DW), .CTL_OFS(CTL_OFS), .STAT_OFS(STAT_OFS),
                 .DONE_CODE(DONE_CODE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .is_sof(is_sof), .is_eof(is_eof), .want_fc(want_fc), .frag_zero(frag_zero),
    .state_q(state_q), .cur_q(cur_q), .own_q(own_q), .fwd_q(fwd_q), .ctl_q(ctl_q),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  txw_evt_out #(.AW(AW)) u_evt (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .cur_q(cur_q), .own_q(own_q),
    .fwd_odd(fwd_q[0]), .busy(busy), .evt_frame(evt_frame), .evt_cmd(evt_cmd),
    .evt_lerr(evt_lerr), .evt_addr(evt_addr)
  );
endmodule

// File: tb/sim_txd_chain_walker.sv
module sim_txd_chain_walker;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam logic [DW-1:0] DONE = 16'h8001;
  localparam int FC = 1, CC = 2, LE = 3;
  // table entry: [7:0] base, [11:8] descriptor count, [19:12] frame-complete mask, [20] stall
  localparam logic [23:0] VEC [0:3] = '{24'h001110, 24'h005320, 24'h100440, 24'h103280};

  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [AW-1:0] start_ptr = '0;
  logic mem_valid, mem_ready, mem_we, mem_rvalid, busy, evt_frame, evt_cmd, evt_lerr;
  logic [AW-1:0] mem_addr, evt_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  txd_chain_walker #(.AW(AW), .DW(DW), .DONE_CODE(DONE)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .busy(busy), .evt_frame(evt_frame), .evt_cmd(evt_cmd), .evt_lerr(evt_lerr),
    .evt_addr(evt_addr)
  );

  // memory model
  logic [DW-1:0] mem [0:255];
  logic stall = 0, hw_en = 0;
  logic [AW-1:0] hw_addr = '0;
  logic [DW-1:0] hw_data = '0;
  logic [1:0] cyc = '0;
  assign mem_ready = !stall || (cyc != 2'd0);
  always @(posedge clk) begin
    cyc <= cyc + 2'd1;
    mem_rvalid <= 1'b0;
    if (hw_en) mem[hw_addr] <= hw_data;
    if (mem_valid && mem_ready) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else begin
        mem_rdata  <= mem[mem_addr];
        mem_rvalid <= 1'b1;
      end
    end
  end

  // observation logs
  int n_log = 0, n_wr = 0, n_rd = 0;
  int log_t [0:31];
  int log_a [0:31];
  int rd_a [0:1];
  logic clr_log = 0;
  always @(negedge clk) begin
    if (clr_log) begin
      n_log = 0; n_wr = 0; n_rd = 0;
    end else begin
      if (evt_frame || evt_cmd || evt_lerr) begin
        if (n_log < 32) begin
          log_t[n_log] = evt_frame ? FC : (evt_cmd ? CC : LE);
          log_a[n_log] = int'(evt_addr);
        end
        n_log++;
      end
      if (mem_valid && mem_ready && mem_we) n_wr++;
      if (mem_valid && mem_ready && !mem_we) begin
        if (n_rd < 2) rd_a[n_rd] = int'(mem_addr);
        n_rd++;
      end
    end
  end

  int tests = 0, fails = 0;
  int n_exp = 0;
  int exp_t [0:31];
  int exp_a [0:31];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); hw_en = 1; hw_addr = AW'(a); hw_data = DW'(d);
    @(negedge clk); hw_en = 0;
  endtask

  task automatic desc(input int a, input int fwd, input int ctl);
    wr(a, fwd); wr(a + 1, ctl); wr(a + 2, 0);
  endtask

  task automatic clear_logs();
    @(negedge clk); clr_log = 1; n_exp = 0;
    @(negedge clk); clr_log = 0;
  endtask

  task automatic expect_evt(input int t, input int a);
    exp_t[n_exp] = t; exp_a[n_exp] = a; n_exp++;
  endtask

  task automatic go(input int p, input string req);
    @(negedge clk); start = 1; start_ptr = AW'(p);
    @(negedge clk); start = 0;
    chk(busy === 1'b1, req, int'(busy), 1);
  endtask

  task automatic wait_idle(input string req);
    bit done = 0;
    for (int i = 0; i < 3000 && !done; i++) begin
      @(negedge clk);
      if (!busy) done = 1;
    end
    chk(done, req, int'(busy), 0);
  endtask

  task automatic cmp_events(input string req);
    chk(n_log == n_exp, req, n_log, n_exp);
    for (int i = 0; i < n_exp && i < n_log; i++) begin
      chk(log_t[i] == exp_t[i], req, log_t[i], exp_t[i]);
      chk(log_a[i] == exp_a[i], req, log_a[i], exp_a[i]);
    end
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !mem_valid, "R1 idle", int'({busy, mem_valid}), 0);
    chk(!evt_frame && !evt_cmd && !evt_lerr, "R1 events", int'({evt_frame, evt_cmd, evt_lerr}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!busy && !mem_valid, "R1 after release", int'({busy, mem_valid}), 0);

    // table of linear chains, one frame per descriptor (R2 R3 R4 R5 R6 R10)
    for (int v = 0; v < 4; v++) begin
      int base, n, last;
      logic [7:0] mask;
      base = int'(VEC[v][7:0]); n = int'(VEC[v][11:8]); mask = VEC[v][19:12];
      stall = VEC[v][20];
      for (int i = 0; i < n; i++) begin
        int a;
        a = base + 4 * i;
        desc(a, (i == n - 1) ? (a | 1) : (a + 4), 16'h0013 | (mask[i] ? 16'h0004 : 16'h0000));
      end
      clear_logs();
      last = base + 4 * (n - 1);
      for (int i = 0; i < n; i++) if (mask[i]) expect_evt(FC, base + 4 * i);
      expect_evt(CC, last);
      go(base, "R2 busy after start");
      wait_idle(stall ? "R10 finish under stall" : "R6 finish");
      cmp_events(stall ? "R10 R5 R6 events" : "R5 R6 events");
      chk(rd_a[0] == base && rd_a[1] == base + 1, "R2 read order", rd_a[1], base + 1);
      chk(n_wr == n, "R4 write count", n_wr, n);
      for (int i = 0; i < n; i++)
        chk(mem[base + 4 * i + 2] == DONE, "R4 status", int'(mem[base + 4 * i + 2]), int'(DONE));
    end
    stall = 0;

    // multi-descriptor frame: status only to owner (R3 R4)
    desc(8'hA0, 8'hA4, 16'h0011);
    desc(8'hA4, 8'hA8, 16'h0010);
    desc(8'hA8, 8'hA9, 16'h0016);
    clear_logs();
    expect_evt(FC, 8'hA0); expect_evt(CC, 8'hA8);
    go(8'hA0, "R2 busy");
    wait_idle("R4 multi finish");
    cmp_events("R3 owner address");
    chk(mem[8'hA2] == DONE, "R4 owner status", int'(mem[8'hA2]), int'(DONE));
    chk(mem[8'hA6] == 0 && mem[8'hAA] == 0, "R4 others untouched", int'(mem[8'hAA]), 0);
    chk(n_wr == 1, "R4 one write", n_wr, 1);

    // odd pointer without end-of-frame ends the frame (R4)
    desc(8'hB0, 8'hB1, 16'h0015);
    clear_logs();
    expect_evt(FC, 8'hB0); expect_evt(CC, 8'hB0);
    go(8'hB0, "R2 busy");
    wait_idle("R4 odd end finish");
    cmp_events("R4 odd end events");
    chk(mem[8'hB2] == DONE, "R4 odd end status", int'(mem[8'hB2]), int'(DONE));

    // late append between frame-complete and reread (R7)
    desc(8'hC0, 8'hC1, 16'h0017);
    desc(8'hD0, 8'hD1, 16'h0013);
    clear_logs();
    expect_evt(FC, 8'hC0); expect_evt(CC, 8'hD0);
    go(8'hC0, "R2 busy");
    begin
      int k = 0;
      while (!evt_frame && k < 200) begin @(negedge clk); k++; end
    end
    hw_en = 1; hw_addr = 8'hC0; hw_data = 16'h00D0;
    @(negedge clk); hw_en = 0;
    wait_idle("R7 finish");
    cmp_events("R7 append events");
    chk(mem[8'hD2] == DONE, "R7 appended status", int'(mem[8'hD2]), int'(DONE));

    // zero fragment count (R9), then restart
    desc(8'hE0, 8'hE1, 16'h0013 & 16'hF00F);
    clear_logs();
    expect_evt(LE, 8'hE0);
    go(8'hE0, "R2 busy");
    wait_idle("R9 stop");
    cmp_events("R9 list error");
    chk(n_wr == 0 && mem[8'hE2] == 0, "R9 no status", n_wr, 0);
    repeat (4) @(negedge clk);
    chk(!busy && !mem_valid, "R9 halted", int'({busy, mem_valid}), 0);
    clear_logs();
    expect_evt(FC, 8'h10); expect_evt(CC, 8'h10);
    go(8'h10, "R9 restart busy");
    wait_idle("R9 restart finish");
    cmp_events("R9 restart events");

    // start while busy ignored (R11)
    stall = 1;
    clear_logs();
    expect_evt(FC, 8'h20); expect_evt(FC, 8'h28); expect_evt(CC, 8'h28);
    go(8'h20, "R2 busy");
    repeat (3) @(negedge clk);
    start = 1; start_ptr = 8'hA0;
    @(negedge clk); start = 0;
    wait_idle("R11 finish");
    cmp_events("R11 ignored start");
    stall = 0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule